// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag Controller

This block gathers the three interrupt causes of a real-time clock (end of a time update, alarm match, and periodic tick) and turns them into one interrupt request. Each cause sets its own sticky flag in a status register whenever it occurs, whatever its enable. A small state machine asserts the active-low request line, and the summary bit in that same status register, only while at least one flag is set together with its enable bit in the control register. A processor polls or services the interrupt by reading the status register through the indexed data port. That read returns the flags and clears them all in the same access.

The block also owns the three alarm registers (seconds, minutes, hours). At each update-end pulse it compares them with the freshly updated time presented on its time inputs. It also provides a read-only validity register whose top bit reports the state of a battery-good input, captured in the first cycle after reset. The time counters and the periodic rate divider are outside the block and arrive only as single-cycle pulses and time values.

The request state machine has three states. IRQ_BOOT is entered on reset and lasts one cycle; in it the validity bit is captured. IRQ_QUIET means no enabled flag is set. IRQ_PENDING means the request is active. The transitions are: boot-to-quiet (no enabled flag after the first edge), boot-to-pending (an enabled flag after the first edge), quiet-to-pending (an enabled flag becomes set, or an enable is written over a flag already set), and pending-to-quiet (a status read clears the flags, or the enables are written off). Quiet and pending each also hold when nothing changes.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, the request output irq_n is 1, reg_rdata is 0x00, and the control register (index 0xB) and status register (index 0xC) read as 0x00.
- R2: An upd_end pulse sets the update flag, which is bit 4 of the status register, whatever the enables are.
- R3: A per_tick pulse sets the periodic flag, which is bit 6 of the status register, whatever the enables are.
- R4: On an upd_end pulse, the alarm flag (status bit 5) sets only if the alarm seconds (index 0x1), alarm minutes (index 0x3) and alarm hours (index 0x5) all equal cur_sec, cur_min and cur_hour. A mismatch in any one field leaves the alarm flag clear.
- R5: Control register bits 4, 5 and 6 enable the update, alarm and periodic flags. Status bit 7 and the inverse of irq_n both equal the OR over the three flags of (flag AND its enable). irq_n changes on the same clock edge as the flag or enable that causes the change.
- R6: A read strobe at index 0xC returns, on reg_rdata after that edge, the flags and the summary bit as they stood before the edge, and clears all four bits at that edge.
- R7: A source pulse in the same cycle as a read of index 0xC leaves its flag set after the clear.
- R8: Bits 3:0 of the status register and bits 6:0 of the validity register (index 0xD) always read as 0.
- R9: Validity register bit 7 holds the value of batt_ok in the first clock cycle after reset. Later changes of batt_ok and writes to index 0xD do not alter it.
- R10: The alarm registers and the control register read back the last value written to them. Every index other than 0x1, 0x3, 0x5, 0xB, 0xC and 0xD reads as 0x00, and writes to those indices have no effect.
- R11: Writes to the status register have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| batt_ok | input | 1 | Battery-good level, captured into the validity bit after reset |
| upd_end | input | 1 | Single-cycle pulse at the end of a time update |
| per_tick | input | 1 | Single-cycle pulse from the periodic rate divider |
| cur_sec | input | 8 | Current seconds value, valid with upd_end |
| cur_min | input | 8 | Current minutes value, valid with upd_end |
| cur_hour | input | 8 | Current hours value, valid with upd_end |
| reg_addr | input | 4 | Register index for a read or write strobe |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data, updated at each read strobe |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest situation to reach is a source pulse that lands in the very cycle of a status read, where the clear and the set meet at one edge. The bench drives the read strobe and upd_end in the same cycle while an older periodic flag is pending. It then checks that the returned value shows only the old flag and that a second read shows only the new one. Around this, the bench sweeps every combination of the three enables against every reachable flag pattern (the alarm flag can only come with an update). For each pair it computes the expected summary bit and request level, then checks both the read-back and the clear.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;

    // register indices whose positions other logic decodes
    localparam logic [3:0] IDX_ALM_SEC  = 4'h1;
    localparam logic [3:0] IDX_ALM_MIN  = 4'h3;
    localparam logic [3:0] IDX_ALM_HOUR = 4'h5;
    localparam logic [3:0] IDX_CTRL     = 4'hB;
    localparam logic [3:0] IDX_STAT     = 4'hC;
    localparam logic [3:0] IDX_VALID    = 4'hD;

    // interrupt sources, in the order of their flag and enable bits
    localparam int N_SRC    = 3;
    localparam int SRC_UPD  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_PER  = 2;
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = 7;

    // alarm fields compared at each update
    localparam int N_FIELD = 3;

    typedef enum logic [1:0] {
        IRQ_BOOT    = 2'd0,
        IRQ_QUIET   = 2'd1,
        IRQ_PENDING = 2'd2
    } irq_state_e;

endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int DW     = 8,
    parameter int NFIELD = 3
) (
    input  logic                   upd_end,
    input  logic [NFIELD-1:0][DW-1:0] alarm_val,
    input  logic [NFIELD-1:0][DW-1:0] time_val,
    output logic                   alarm_hit
);

    logic [NFIELD-1:0] field_eq;

    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        assign field_eq[f] = (alarm_val[f] == time_val[f]);
    end

    assign alarm_hit = upd_end && (&field_eq);

endmodule

// File: rtl/rtc_flag_bank.sv
module rtc_flag_bank #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_set,
    input  logic            clr_all,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] flags_nxt
);

    for (genvar s = 0; s < NSRC; s++) begin : g_flag
        // a new event wins over the clear of the same cycle
        always_comb begin
            if (src_set[s])
                flags_nxt[s] = 1'b1;
            else if (clr_all)
                flags_nxt[s] = 1'b0;
            else
                flags_nxt[s] = flags[s];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[s] <= 1'b0;
            else
                flags[s] <= flags_nxt[s];
        end
    end

endmodule

// File: rtl/rtc_irq_fsm.sv
module rtc_irq_fsm
    import rtc_irq_pkg::*;
#(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            batt_ok,
    input  logic [NSRC-1:0] flags_nxt,
    input  logic [NSRC-1:0] en_nxt,
    output logic            irq_sum,
    output logic            irq_n,
    output logic            valid_bit
);

    irq_state_e state_q;
    irq_state_e state_d;
    logic       any_nxt;

    assign any_nxt = |(flags_nxt & en_nxt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= IRQ_BOOT;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_BOOT:    state_d = any_nxt ? IRQ_PENDING : IRQ_QUIET;
            IRQ_QUIET:   if (any_nxt)  state_d = IRQ_PENDING;
            IRQ_PENDING: if (!any_nxt) state_d = IRQ_QUIET;
            default:     state_d = IRQ_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        irq_sum = (state_q == IRQ_PENDING);
        irq_n   = !irq_sum;
    end

    // validity bit captured once, in the boot state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            valid_bit <= 1'b0;
        else if (state_q == IRQ_BOOT)
            valid_bit <= batt_ok;
    end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          batt_ok,
    input  logic          upd_end,
    input  logic          per_tick,
    input  logic [DW-1:0] cur_sec,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_n
);

    localparam int EN_MSB = FLAG_LSB + N_SRC - 1;

    logic [N_FIELD-1:0][DW-1:0] alarm_q;
    logic [N_FIELD-1:0][DW-1:0] time_in;
    logic [DW-1:0]              ctrl_q;
    logic [DW-1:0]              ctrl_nxt;
    logic [N_SRC-1:0]           src_set;
    logic [N_SRC-1:0]           flag_q;
    logic [N_SRC-1:0]           flag_nxt;
    logic                       alarm_hit;
    logic                       stat_rd;
    logic                       irq_sum;
    logic                       valid_bit;
    logic [DW-1:0]              rd_val;
    logic [DW-1:0]              rdata_q;

    assign time_in = {cur_hour, cur_min, cur_sec};

    // alarm registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == IDX_ALM_SEC)  alarm_q[0] <= reg_wdata;
            if (reg_addr == IDX_ALM_MIN)  alarm_q[1] <= reg_wdata;
            if (reg_addr == IDX_ALM_HOUR) alarm_q[2] <= reg_wdata;
        end
    end

    // control register with its next value for the request machine
    assign ctrl_nxt = (reg_wr && reg_addr == IDX_CTRL) ? reg_wdata : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_nxt;
    end

    rtc_alarm_cmp #(
        .DW     (DW),
        .NFIELD (N_FIELD)
    ) u_cmp (
        .upd_end   (upd_end),
        .alarm_val (alarm_q),
        .time_val  (time_in),
        .alarm_hit (alarm_hit)
    );

    always_comb begin
        src_set          = '0;
        src_set[SRC_UPD] = upd_end;
        src_set[SRC_ALM] = alarm_hit;
        src_set[SRC_PER] = per_tick;
    end

    assign stat_rd = reg_rd && (reg_addr == IDX_STAT);

    rtc_flag_bank #(
        .NSRC (N_SRC)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_set   (src_set),
        .clr_all   (stat_rd),
        .flags     (flag_q),
        .flags_nxt (flag_nxt)
    );

    rtc_irq_fsm #(
        .NSRC (N_SRC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .batt_ok   (batt_ok),
        .flags_nxt (flag_nxt),
        .en_nxt    (ctrl_nxt[EN_MSB:FLAG_LSB]),
        .irq_sum   (irq_sum),
        .irq_n     (irq_n),
        .valid_bit (valid_bit)
    );

    // read multiplexer
    always_comb begin
        rd_val = '0;
        unique case (reg_addr)
            IDX_ALM_SEC:  rd_val = alarm_q[0];
            IDX_ALM_MIN:  rd_val = alarm_q[1];
            IDX_ALM_HOUR: rd_val = alarm_q[2];
            IDX_CTRL:     rd_val = ctrl_q;
            IDX_STAT: begin
                rd_val[EN_MSB:FLAG_LSB] = flag_q;
                rd_val[SUM_BIT]         = irq_sum;
            end
            IDX_VALID:    rd_val[SUM_BIT] = valid_bit;
            default:      rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (reg_rd)
            rdata_q <= rd_val;
    end

    assign reg_rdata = rdata_q;

endmodule

// File: rtl/rtc_irq_chk.sv
module rtc_irq_chk #(
    parameter int DW   = 8,
    parameter int AW   = 4,
    parameter int NSRC = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   reg_addr,
    input logic            reg_rd,
    input logic [DW-1:0]   reg_rdata,
    input logic            irq_n,
    input logic [NSRC-1:0] flags,
    input logic [NSRC-1:0] en,
    input logic [NSRC-1:0] src_set
);

    localparam logic [AW-1:0] A_STAT  = AW'(12);
    localparam logic [AW-1:0] A_VALID = AW'(13);

    // R5: request level follows enabled flags
    a_r5_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n == !(|(flags & en)));

    // R2 R3 R4 R7: every source event is held after its edge, even over a clear
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_set) |=> ((flags & $past(src_set)) == $past(src_set)));

    // R6: a status read with no new event empties the flags
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STAT && src_set == '0) |=> (flags == '0));

    // R11: without a status read no flag ever drops
    a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_STAT) |=> ((flags & $past(flags)) == $past(flags)));

    // R8: unused validity bits read as zero
    a_r8_valid_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_VALID) |=> (reg_rdata[6:0] == 7'd0));

    // R8: unused status bits read as zero
    a_r8_stat_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STAT) |=> (reg_rdata[3:0] == 4'd0));

endmodule

bind rtc_irq_ctrl rtc_irq_chk #(
    .DW   (DW),
    .AW   (AW),
    .NSRC (rtc_irq_pkg::N_SRC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .flags     (flag_q),
    .en        (ctrl_q[6:4]),
    .src_set   (src_set)
);

// File: tb/sim_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module sim_rtc_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       batt_ok = 1'b1;
    logic       upd_end = 1'b0;
    logic       per_tick = 1'b0;
    logic [7:0] cur_sec = 8'h00;
    logic [7:0] cur_min = 8'h00;
    logic [7:0] cur_hour = 8'h00;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int n_checks = 0;
    int n_errors = 0;

    localparam logic [7:0] AL_S = 8'h56;
    localparam logic [7:0] AL_M = 8'h34;
    localparam logic [7:0] AL_H = 8'h12;

    always #2 clk = ~clk;

    rtc_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .batt_ok   (batt_ok),
        .upd_end   (upd_end),
        .per_tick  (per_tick),
        .cur_sec   (cur_sec),
        .cur_min   (cur_min),
        .cur_hour  (cur_hour),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        report();
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        reg_rd = 1'b1; reg_addr = a;
        step();
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic fire(input logic u, input logic p,
                        input logic [7:0] s, input logic [7:0] m, input logic [7:0] h);
        upd_end = u; per_tick = p; cur_sec = s; cur_min = m; cur_hour = h;
        step();
        upd_end = 1'b0; per_tick = 1'b0;
    endtask

    task automatic do_reset(input logic batt);
        batt_ok = batt;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] exp_c;
        logic       sum;

        @(negedge clk);
        do_reset(1'b1);

        // reset state
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        chk("R1 rdata", reg_rdata, 8'h00);
        rd(4'hB, v); chk("R1 ctrl", v, 8'h00);
        rd(4'hC, v); chk("R1 stat", v, 8'h00);

        // validity register
        rd(4'hD, v); chk("R9 R8 valid batt=1", v, 8'h80);
        batt_ok = 1'b0;
        step();
        rd(4'hD, v); chk("R9 valid holds after batt drop", v, 8'h80);
        wr(4'hD, 8'h00);
        rd(4'hD, v); chk("R9 valid write ignored", v, 8'h80);

        // alarm and control read-back, unmapped indices
        wr(4'h1, AL_S); wr(4'h3, AL_M); wr(4'h5, AL_H);
        rd(4'h1, v); chk("R10 alarm sec", v, AL_S);
        rd(4'h3, v); chk("R10 alarm min", v, AL_M);
        rd(4'h5, v); chk("R10 alarm hour", v, AL_H);
        wr(4'hB, 8'hA5);
        rd(4'hB, v); chk("R10 ctrl", v, 8'hA5);
        wr(4'hB, 8'h00);
        wr(4'h2, 8'h77);
        rd(4'h2, v); chk("R10 unmapped 2", v, 8'h00);
        rd(4'h0, v); chk("R10 unmapped 0", v, 8'h00);
        rd(4'hE, v); chk("R10 unmapped E", v, 8'h00);

        // sweep: every enable set against every reachable flag pattern
        for (int en = 0; en < 8; en++) begin
            for (int pat = 0; pat < 8; pat++) begin
                if (pat[1] && !pat[0]) continue;
                rd(4'hC, v);
                wr(4'hB, 8'(en << 4));
                fire(pat[0], pat[2],
                     AL_S, AL_M, pat[1] ? AL_H : (AL_H ^ 8'h01));
                sum = |(3'(pat) & 3'(en));
                chk("R5 irq_n level", {7'd0, irq_n}, {7'd0, !sum});
                exp_c = {sum, 3'(pat), 4'h0};
                rd(4'hC, v); chk("R2 R3 R4 R5 stat value", v, exp_c);
                chk("R6 irq_n after read", {7'd0, irq_n}, 8'h01);
                rd(4'hC, v); chk("R6 stat cleared", v, 8'h00);
            end
        end
        wr(4'hB, 8'h00);

        // alarm mismatch on each field alone
        for (int f = 0; f < 3; f++) begin
            rd(4'hC, v);
            fire(1'b1, 1'b0,
                 (f == 0) ? (AL_S ^ 8'h10) : AL_S,
                 (f == 1) ? (AL_M ^ 8'h02) : AL_M,
                 (f == 2) ? (AL_H ^ 8'h04) : AL_H);
            rd(4'hC, v); chk("R4 field mismatch", v, 8'h10);
        end

        // enable written over a flag already set
        rd(4'hC, v);
        fire(1'b0, 1'b1, 8'h00, 8'h00, 8'h00);
        chk("R5 flag without enable", {7'd0, irq_n}, 8'h01);
        wr(4'hB, 8'h40);
        chk("R5 enable raises irq", {7'd0, irq_n}, 8'h00);
        wr(4'hB, 8'h00);
        chk("R5 disable drops irq", {7'd0, irq_n}, 8'h01);

        // event in the same cycle as a status read
        reg_rd = 1'b1; reg_addr = 4'hC;
        upd_end = 1'b1; cur_sec = 8'h00; cur_min = 8'h00; cur_hour = 8'h00;
        step();
        reg_rd = 1'b0; upd_end = 1'b0;
        chk("R7 read returns old flag", reg_rdata, 8'h40);
        rd(4'hC, v); chk("R7 new flag survives", v, 8'h10);

        // writes to the status register
        fire(1'b1, 1'b1, 8'h00, 8'h00, 8'h00);
        wr(4'hC, 8'h00);
        rd(4'hC, v); chk("R11 write to stat ignored", v, 8'h50);

        // validity captured low
        do_reset(1'b0);
        batt_ok = 1'b1;
        step();
        rd(4'hD, v); chk("R9 valid batt=0", v, 8'h00);
        chk("R1 irq_n second reset", {7'd0, irq_n}, 8'h01);

        report();
    end

endmodule